// File: doc/BRIEF.md
# Three-Bank Programmable Clock Post-Divider

This block divides one fast source clock into three independent output clocks, called banks A, B and C. Each bank has its own 3-bit select code. The code picks one of seven even divide ratios, or it switches the bank off. Each bank drives a true output and a complement output. Every ratio is even, so each output is high for exactly half of its period.

All three banks share an active-low resynchronisation strobe. While the strobe is low, every bank counter is cleared and every true output is held low. When the strobe returns high, all banks start counting on the same source edge, so their rising edges line up again after any of them has been reprogrammed. The select codes can be changed while the clock runs. A running bank takes up a new code only at the end of its current full output period, so a code change never shortens a pulse.

Top module: `clk_bank_divider`

## Requirements
- R1: Select codes 1, 2, 3, 4, 5, 6 and 7 divide the source clock by 2, 4, 6, 8, 10, 12 and 18 respectively, and the true output stays high for exactly half the ratio in source cycles.
- R2: Select code 0 disables the bank: the true output is held low and the complement output high. A running bank that is given code 0 first completes its current output period.
- R3: On every bank, the complement output is always the inverse of the true output.
- R4: Each bank divides according to its own select code only. The codes of the other banks have no effect on it.
- R5: From the second rising source edge after the strobe is sampled low, and for as long as it stays low, every bank counter is cleared and every true output is low.
- R6: After the strobe is sampled high again, the next rising edge is the first active edge for all banks together. An enabled bank's true output first rises on active edge ratio/2.
- R7: A code change on a running bank takes effect only at the falling edge of its true output, which ends a full period. Until then the bank keeps its previous ratio.
- R8: A disabled bank that receives a non-zero code takes it on the next rising edge. Its output first rises ratio/2 edges later, with no strobe needed.
- R9: The asynchronous active-low reset drives all true outputs low. After reset is released, the banks start as on a strobe release with the codes present, so all-ones codes give a ratio of 18.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Source clock to be divided |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync_n | input | 1 | Shared resynchronisation strobe, active low |
| sel_a | input | 3 | Bank A select code |
| sel_b | input | 3 | Bank B select code |
| sel_c | input | 3 | Bank C select code |
| qa | output | 1 | Bank A true output |
| qa_n | output | 1 | Bank A complement output |
| qb | output | 1 | Bank B true output |
| qb_n | output | 1 | Bank B complement output |
| qc | output | 1 | Bank C true output |
| qc_n | output | 1 | Bank C complement output |

## Verification
The properties assume that the strobe and all three select codes are synchronous to the source clock and stable around each rising edge. The properties also count edges from the first edge at which the strobe is sampled low. The stimulus keeps to this by changing every input only on the falling source edge. It holds the strobe low for at least two rising edges before each release, and it changes codes only while reset is inactive. Expected outputs come from the ratio table and from edge counts taken from the release or from the moment a code changes.

// File: rtl/clk_bank_divider.sv
module clk_bank_divider (
  input  logic       clk_src,
  input  logic       rst_n,
  input  logic       sync_n,
  input  logic [2:0] sel_a,
  input  logic [2:0] sel_b,
  input  logic [2:0] sel_c,
  output logic       qa,
  output logic       qa_n,
  output logic       qb,
  output logic       qb_n,
  output logic       qc,
  output logic       qc_n
);
  localparam int NB = 3;
  localparam int CW = 4;

  function automatic logic [CW-1:0] half_of(input logic [2:0] code);
    case (code)
      3'd1:    half_of = CW'(1);
      3'd2:    half_of = CW'(2);
      3'd3:    half_of = CW'(3);
      3'd4:    half_of = CW'(4);
      3'd5:    half_of = CW'(5);
      3'd6:    half_of = CW'(6);
      3'd7:    half_of = CW'(9);
      default: half_of = CW'(1);
    endcase
  endfunction

  logic          sync_q;
  logic [2:0]    sel [NB];
  logic [2:0]    act [NB];
  logic [CW-1:0] cnt [NB];
  logic          qv  [NB];

  assign sel[0] = sel_a;
  assign sel[1] = sel_b;
  assign sel[2] = sel_c;

  always_ff @(posedge clk_src or negedge rst_n)
    if (!rst_n) sync_q <= 1'b0;
    else        sync_q <= sync_n;

  for (genvar g = 0; g < NB; g++) begin : g_bank
    always_ff @(posedge clk_src or negedge rst_n) begin
      if (!rst_n) begin
        act[g] <= 3'd0;
        cnt[g] <= '0;
        qv[g]  <= 1'b0;
      end else if (!sync_q || act[g] == 3'd0) begin
        act[g] <= sel[g];
        cnt[g] <= '0;
        qv[g]  <= 1'b0;
      end else if (cnt[g] == half_of(act[g]) - CW'(1)) begin
        cnt[g] <= '0;
        qv[g]  <= ~qv[g];
        if (qv[g]) act[g] <= sel[g];
      end else begin
        cnt[g] <= cnt[g] + CW'(1);
      end
    end
  end

  assign qa   = qv[0];
  assign qa_n = ~qv[0];
  assign qb   = qv[1];
  assign qb_n = ~qv[1];
  assign qc   = qv[2];
  assign qc_n = ~qv[2];
endmodule

// File: rtl/clk_bank_divider_chk.sv
module clk_bank_divider_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sync_n,
  input logic       sync_q,
  input logic       qa,
  input logic       qa_n,
  input logic       qb,
  input logic       qb_n,
  input logic       qc,
  input logic       qc_n,
  input logic [2:0] act_a,
  input logic [2:0] act_b,
  input logic [2:0] act_c
);
  // R3
  complement_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (qa_n == !qa) && (qb_n == !qb) && (qc_n == !qc));

  // R5
  hold_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_n |=> ##1 (!qa && !qb && !qc));

  // R2
  disabled_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_a == 3'd0) |=> !qa);

  // R2
  disabled_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_b == 3'd0) |=> !qb);

  // R2
  disabled_c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_c == 3'd0) |=> !qc);

  // R7
  switch_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_a) |-> (!$past(sync_q) || $past(act_a) == 3'd0 || ($past(qa) && !qa)));

  // R7
  switch_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_b) |-> (!$past(sync_q) || $past(act_b) == 3'd0 || ($past(qb) && !qb)));

  // R7
  switch_c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_c) |-> (!$past(sync_q) || $past(act_c) == 3'd0 || ($past(qc) && !qc)));
endmodule

bind clk_bank_divider clk_bank_divider_chk chk_i (
  .clk(clk_src), .rst_n(rst_n), .sync_n(sync_n), .sync_q(sync_q),
  .qa(qa), .qa_n(qa_n), .qb(qb), .qb_n(qb_n), .qc(qc), .qc_n(qc_n),
  .act_a(act[0]), .act_b(act[1]), .act_c(act[2])
);

// File: tb/clk_bank_divider_tb_top.sv
module clk_bank_divider_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  localparam logic [8:0] VEC [NVEC] = '{
    {3'd1, 3'd2, 3'd3}, {3'd4, 3'd5, 3'd6}, {3'd7, 3'd0, 3'd1}, {3'd0, 3'd7, 3'd4},
    {3'd2, 3'd2, 3'd2}, {3'd6, 3'd1, 3'd7}, {3'd3, 3'd4, 3'd5}, {3'd5, 3'd6, 3'd0}
  };

  logic clk_src = 1'b0;
  logic rst_n = 1'b0;
  logic sync_n = 1'b1;
  logic [2:0] sel_a = 3'd7, sel_b = 3'd7, sel_c = 3'd7;
  logic qa, qa_n, qb, qb_n, qc, qc_n;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_src = ~clk_src;

  clk_bank_divider dut_i (
    .clk_src(clk_src), .rst_n(rst_n), .sync_n(sync_n),
    .sel_a(sel_a), .sel_b(sel_b), .sel_c(sel_c),
    .qa(qa), .qa_n(qa_n), .qb(qb), .qb_n(qb_n), .qc(qc), .qc_n(qc_n)
  );

  function automatic logic exp_q(input logic [2:0] code, input int n);
    int h;
    case (code)
      3'd1: h = 1;
      3'd2: h = 2;
      3'd3: h = 3;
      3'd4: h = 4;
      3'd5: h = 5;
      3'd6: h = 6;
      3'd7: h = 9;
      default: return 1'b0;
    endcase
    return ((n / h) % 2) == 1;
  endfunction

  task automatic chk(input string req, input logic actual, input logic expected);
    checks++;
    if (actual !== expected) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, actual, expected, $time);
    end
  endtask

  task automatic chk_bank(input string req, input logic q, input logic qn, input logic e);
    chk(req, q, e);
    chk({req, " R3"}, qn, ~e);
  endtask

  task automatic hold_and_load(input logic [2:0] a, input logic [2:0] b, input logic [2:0] c);
    @(negedge clk_src);
    sync_n = 1'b0;
    sel_a = a; sel_b = b; sel_c = c;
    @(negedge clk_src);
    @(negedge clk_src);
    chk_bank("R5 bank A held", qa, qa_n, 1'b0);
    chk_bank("R5 bank B held", qb, qb_n, 1'b0);
    chk_bank("R5 bank C held", qc, qc_n, 1'b0);
    sync_n = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    // R9 reset state
    #(CLK_PERIOD * 2 + 1);
    chk_bank("R9 reset bank A", qa, qa_n, 1'b0);
    chk_bank("R9 reset bank B", qb, qb_n, 1'b0);
    chk_bank("R9 reset bank C", qc, qc_n, 1'b0);
    @(negedge clk_src);
    rst_n = 1'b1;
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk_src);
      chk_bank("R9 default ratio A", qa, qa_n, exp_q(3'd7, k - 1));
      chk_bank("R9 default ratio B", qb, qb_n, exp_q(3'd7, k - 1));
      chk_bank("R9 default ratio C", qc, qc_n, exp_q(3'd7, k - 1));
    end

    // R1 R4 R6 vector walk
    for (int v = 0; v < NVEC; v++) begin
      hold_and_load(VEC[v][8:6], VEC[v][5:3], VEC[v][2:0]);
      for (int k = 1; k <= 40; k++) begin
        @(negedge clk_src);
        chk_bank("R1 R4 R6 bank A", qa, qa_n, exp_q(VEC[v][8:6], k - 1));
        chk_bank("R1 R4 R6 bank B", qb, qb_n, exp_q(VEC[v][5:3], k - 1));
        chk_bank("R1 R4 R6 bank C", qc, qc_n, exp_q(VEC[v][2:0], k - 1));
      end
    end

    // R7 switch bank A from 18 to 2 mid-period; R8 wake bank C from disabled
    hold_and_load(3'd7, 3'd1, 3'd0);
    for (int k = 1; k <= 31; k++) begin
      @(negedge clk_src);
      if (k - 1 <= 18) chk_bank("R7 old ratio kept A", qa, qa_n, exp_q(3'd7, k - 1));
      else             chk_bank("R7 new ratio A", qa, qa_n, ((k - 1 - 18) % 2) == 1);
      chk_bank("R4 bank B unaffected", qb, qb_n, exp_q(3'd1, k - 1));
      chk_bank("R2 bank C disabled", qc, qc_n, 1'b0);
      if (k == 6) sel_a = 3'd1;
    end
    sel_c = 3'd2;
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk_src);
      chk_bank("R8 bank C wakes", qc, qc_n, exp_q(3'd2, k - 1));
    end

    // R2 bank B disabled mid-run finishes current period
    hold_and_load(3'd3, 3'd3, 3'd3);
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk_src);
      chk_bank("R2 bank B stop", qb, qb_n, (k - 1 < 6) ? exp_q(3'd3, k - 1) : 1'b0);
      chk_bank("R4 bank A keeps", qa, qa_n, exp_q(3'd3, k - 1));
      if (k == 2) sel_b = 3'd0;
    end

    // R5 long hold keeps outputs low
    @(negedge clk_src);
    sync_n = 1'b0;
    @(negedge clk_src);
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk_src);
      chk_bank("R5 long hold A", qa, qa_n, 1'b0);
      chk_bank("R5 long hold C", qc, qc_n, 1'b0);
    end
    sync_n = 1'b1;
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk_src);
      chk_bank("R6 release A", qa, qa_n, exp_q(3'd3, k - 1));
      chk_bank("R6 release C", qc, qc_n, exp_q(3'd3, k - 1));
    end
    finish_run();
  end
endmodule